// File: doc/BRIEF.md
# Dual-Clock Five-Word Packing FIFO

This block sits between a producer that emits 32-bit words on its own clock and a consumer that wants those words five at a time, as one 160-bit word, on an unrelated clock. The writer presents a word with a write enable whenever the `full` flag is low. The block keeps a running count of words in the current group and parks the first four in holding registers. When the fifth word arrives, the group is pushed as a single 160-bit entry into a 16-entry storage queue.

The two sides exchange only Gray-coded queue pointers, each passed through a two-stage synchroniser. Every port signal is generated and sampled on the clock of its own side, so the clock ratio can be any value, including one that is not an integer. The consumer sees the oldest complete group on `dout` whenever `empty` is low. Asserting the read enable moves `dout` to the next entry.

One reset input is sampled synchronously by each clock. It returns both sides to an idle state in which nothing is written or read. It also drops any partly assembled group.

Top module: `wide_pack_fifo`

## Requirements
- R1: Each accepted read returns exactly five accepted 32-bit input words as one 160-bit word.
- R2: Groups follow write order. Accepted words 1 to 5 form the first entry and words 6 to 10 the second. Within an entry, the earliest word sits in bits [31:0] and the latest in bits [159:128].
- R3: A word is taken only on a write-clock edge where `wr_en` is 1 and `full` is 0. A write while `full` is 1 is dropped and never appears on `dout`.
- R4: `dout` shows the head entry whenever `empty` is 0. It moves to the next entry only on a read-clock edge where `rd_en` is 1 and `empty` is 0. A read while `empty` is 1 has no effect.
- R5: A group of fewer than five words stays invisible to the reader, and `empty` remains 1, until its fifth word is accepted.
- R6: While reset is high, `full` and `empty` both read 1. They stay 1 through the first edge of their own clock after reset falls, and show true occupancy from then on.
- R7: The queue holds 16 complete groups. Once 16 groups are stored and none has been read, `full` is 1 and stays 1 until a read frees space.
- R8: Both flags are conservative. `empty` is never 0 while no complete group is stored, and `full` is never 0 while 16 groups are stored. When both ports have been idle for a few cycles of each clock, `empty` equals "no groups stored" and `full` equals "16 groups stored".
- R9: Behaviour holds for any clock ratio, including a read clock about 3.33 times slower than the write clock, and a read clock faster than the write clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Reset, high, sampled synchronously by each clock |
| wr_clk | input | 1 | Write-side clock |
| wr_en | input | 1 | Write request for `din` |
| din | input | 32 | Input word |
| full | output | 1 | Write side cannot accept a word |
| rd_clk | input | 1 | Read-side clock |
| rd_en | input | 1 | Read request; advances `dout` |
| dout | output | 160 | Head entry, five packed words |
| empty | output | 1 | No complete group available |

## Verification
A wrong group counter or a misplaced holding slot shows at the read port as soon as the affected group reaches the head. The symptom is a word in the wrong 32-bit lane or a word taken from a neighbouring group. A pointer that advances or wraps incorrectly shows either as a repeated or skipped entry on the next read, or as a flag that disagrees with the queue's true occupancy once both sides are idle. A dropped write that leaks into storage shifts every later word by one position, so the very next group compared fails.

// File: rtl/wide_pack_fifo.sv
module wide_pack_fifo #(
  parameter int DW    = 32,
  parameter int GROUP = 5,
  parameter int AW    = 4
) (
  input  logic                rst,
  input  logic                wr_clk,
  input  logic                wr_en,
  input  logic [DW-1:0]       din,
  output logic                full,
  input  logic                rd_clk,
  input  logic                rd_en,
  output logic [DW*GROUP-1:0] dout,
  output logic                empty
);
  localparam int OW    = DW * GROUP;
  localparam int HW    = DW * (GROUP - 1);
  localparam int DEPTH = 1 << AW;
  localparam int CW    = $clog2(GROUP);

  function automatic logic [AW:0] to_gray(input logic [AW:0] b);
    return b ^ (b >> 1);
  endfunction

  logic [OW-1:0] mem [DEPTH];
  logic [HW-1:0] hold;
  logic [CW-1:0] cnt;
  logic [AW:0]   wbin, wgray, rq1, rq2;
  logic [AW:0]   rbin, rgray, wq1, wq2;
  logic          wr_boot, rd_boot;

  wire wr_go   = wr_en & ~full & ~rst;
  wire last    = (cnt == CW'(GROUP - 1));
  wire rd_go   = rd_en & ~empty & ~rst;
  wire [AW:0] wbin_n = wbin + 1'b1;
  wire [AW:0] rbin_n = rbin + 1'b1;

  assign full  = wr_boot | (wgray == {~rq2[AW:AW-1], rq2[AW-2:0]});
  assign empty = rd_boot | (rgray == wq2);
  assign dout  = mem[rbin[AW-1:0]];

  always_ff @(posedge wr_clk) begin
    if (rst) begin
      wbin    <= '0;
      wgray   <= '0;
      cnt     <= '0;
      rq1     <= '0;
      rq2     <= '0;
      wr_boot <= 1'b1;
    end else begin
      wr_boot <= 1'b0;
      rq1     <= rgray;
      rq2     <= rq1;
      if (wr_go) begin
        if (last) begin
          cnt   <= '0;
          wbin  <= wbin_n;
          wgray <= to_gray(wbin_n);
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge wr_clk) begin
    if (wr_go && !last) begin
      for (int i = 0; i < GROUP - 1; i++)
        if (cnt == CW'(i)) hold[i*DW +: DW] <= din;
    end
  end

  always_ff @(posedge wr_clk) begin
    if (wr_go && last) mem[wbin[AW-1:0]] <= {din, hold};
  end

  always_ff @(posedge rd_clk) begin
    if (rst) begin
      rbin    <= '0;
      rgray   <= '0;
      wq1     <= '0;
      wq2     <= '0;
      rd_boot <= 1'b1;
    end else begin
      rd_boot <= 1'b0;
      wq1     <= wgray;
      wq2     <= wq1;
      if (rd_go) begin
        rbin  <= rbin_n;
        rgray <= to_gray(rbin_n);
      end
    end
  end
endmodule

// File: rtl/wide_pack_fifo_chk.sv
module wide_pack_fifo_chk #(
  parameter int DW    = 32,
  parameter int GROUP = 5,
  parameter int AW    = 4
) (
  input logic                rst,
  input logic                wr_clk,
  input logic                rd_clk,
  input logic                wr_en,
  input logic                rd_en,
  input logic                full,
  input logic                empty,
  input logic [DW*GROUP-1:0] dout,
  input logic [AW:0]         wbin,
  input logic [AW:0]         wgray,
  input logic [AW:0]         rbin,
  input logic [AW:0]         rgray,
  input logic [$clog2(GROUP)-1:0] cnt
);
  p_reset_full_r6: assert property (@(posedge wr_clk) rst |=> full)
    else $error("R6 full low after reset edge");
  p_reset_empty_r6: assert property (@(posedge rd_clk) rst |=> empty)
    else $error("R6 empty low after reset edge");
  p_no_overflow_r3: assert property (@(posedge wr_clk) disable iff (rst)
      (wr_en && full) |=> (wbin == $past(wbin) && cnt == $past(cnt)))
    else $error("R3 write taken while full");
  p_no_underflow_r4: assert property (@(posedge rd_clk) disable iff (rst)
      (rd_en && empty) |=> (rbin == $past(rbin)))
    else $error("R4 read taken while empty");
  p_head_hold_r4: assert property (@(posedge rd_clk) disable iff (rst)
      (!rd_en && !empty) |=> $stable(dout))
    else $error("R4 head changed without read");
  p_group_cnt_r5: assert property (@(posedge wr_clk) disable iff (rst)
      cnt < GROUP)
    else $error("R5 group counter out of range");
  p_gray_wr_r8: assert property (@(posedge wr_clk) disable iff (rst)
      $countones(wgray ^ $past(wgray)) <= 1)
    else $error("R8 write pointer moved by more than one bit");
  p_gray_rd_r8: assert property (@(posedge rd_clk) disable iff (rst)
      $countones(rgray ^ $past(rgray)) <= 1)
    else $error("R8 read pointer moved by more than one bit");
endmodule

bind wide_pack_fifo wide_pack_fifo_chk #(.DW(DW), .GROUP(GROUP), .AW(AW)) u_chk (
  .rst(rst), .wr_clk(wr_clk), .rd_clk(rd_clk), .wr_en(wr_en), .rd_en(rd_en),
  .full(full), .empty(empty), .dout(dout), .wbin(wbin), .wgray(wgray),
  .rbin(rbin), .rgray(rgray), .cnt(cnt)
);

// File: tb/sim_wide_pack_fifo.sv
`timescale 1ns/1ps
module sim_wide_pack_fifo;
  localparam int DW = 32, GROUP = 5, AW = 4, DEPTH = 1 << AW;
  localparam int OW = DW * GROUP;

  logic rst = 1'b1, wr_clk = 1'b0, rd_clk = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] din = '0;
  logic full, empty;
  logic [OW-1:0] dout;

  real rd_half = 13.332;
  int  tests = 0, fails = 0;
  int  rd_pct = 0, ignored = 0;
  logic [DW-1:0] next_val = 32'h1000_0001;
  logic [OW-1:0] q[$];
  logic [DW-1:0] part[$];

  wide_pack_fifo #(.DW(DW), .GROUP(GROUP), .AW(AW)) u0 (
    .rst(rst), .wr_clk(wr_clk), .wr_en(wr_en), .din(din), .full(full),
    .rd_clk(rd_clk), .rd_en(rd_en), .dout(dout), .empty(empty));

  always #4 wr_clk = ~wr_clk;
  always #(rd_half) rd_clk = ~rd_clk;

  task automatic check(input bit ok, input string req, input logic [OW-1:0] act, input logic [OW-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge rd_clk) begin
    if (rst) rd_en <= 1'b0;
    else begin
      logic e, nxt;
      logic [OW-1:0] d;
      e = empty;
      d = dout;
      if (q.size() == 0) check(e === 1'b1, "R8 empty with no group stored", OW'(e), OW'(1));
      nxt = ($urandom % 100) < rd_pct;
      if (nxt && !e) begin
        if (q.size() == 0) check(1'b0, "R4 data shown with nothing stored", d, '0);
        else begin
          logic [OW-1:0] x;
          x = q.pop_front();
          check(d === x, "R1 R2 packed group order", d, x);
        end
      end
      rd_en <= nxt;
    end
  end

  task automatic drive(input int attempts, input int pct);
    for (int k = 0; k < attempts; k++) begin
      @(negedge wr_clk);
      begin
        logic f;
        f = full;
        if (q.size() == DEPTH) check(f === 1'b1, "R7 full with 16 groups", OW'(f), OW'(1));
        if (($urandom % 100) < pct) begin
          wr_en = 1'b1;
          if (!f) begin
            din = next_val;
            part.push_back(next_val);
            next_val++;
            if (part.size() == GROUP) begin
              logic [OW-1:0] g;
              for (int i = 0; i < GROUP; i++) g[i*DW +: DW] = part[i];
              q.push_back(g);
              part.delete();
            end
          end else begin
            din = 32'hDEAD_0000 | DW'(k);
            ignored++;
          end
        end else wr_en = 1'b0;
      end
    end
    @(negedge wr_clk) wr_en = 1'b0;
  endtask

  task automatic settle();
    int keep;
    keep = rd_pct;
    rd_pct = 0;
    wr_en = 1'b0;
    repeat (12) @(negedge rd_clk);
    @(negedge rd_clk);
    check(empty === (q.size() == 0), "R8 R5 empty settles to occupancy", OW'(empty), OW'(q.size() == 0));
    @(negedge wr_clk);
    check(full === (q.size() == DEPTH), "R8 R7 full settles to occupancy", OW'(full), OW'(q.size() == DEPTH));
    rd_pct = keep;
  endtask

  task automatic finish_group();
    while (part.size() != 0) drive(1, 100);
  endtask

  task automatic drain();
    rd_pct = 100;
    while (q.size() != 0) @(negedge rd_clk);
    repeat (4) @(negedge rd_clk);
    rd_pct = 0;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge rd_clk);
    check(full === 1'b1, "R6 full during reset", OW'(full), OW'(1));
    check(empty === 1'b1, "R6 empty during reset", OW'(empty), OW'(1));
    @(negedge wr_clk) rst = 1'b0;
    @(negedge wr_clk);
    check(full === 1'b0, "R6 full shows true state after start", OW'(full), OW'(0));
    repeat (2) @(negedge rd_clk);
    check(empty === 1'b1, "R6 empty after start", OW'(empty), OW'(1));

    rd_pct = 100;
    drive(200, 70);
    finish_group();
    settle();
    drain();

    drive(3, 100);
    settle();
    check(empty === 1'b1, "R5 partial group hidden", OW'(empty), OW'(1));
    drive(2, 100);
    settle();
    check(empty === 1'b0, "R5 group visible after fifth word", OW'(empty), OW'(0));
    drain();

    ignored = 0;
    drive(100, 100);
    settle();
    check(full === 1'b1, "R7 full after 16 groups", OW'(full), OW'(1));
    check(ignored > 0, "R3 writes while full dropped", OW'(ignored), OW'(1));
    drain();
    settle();

    rd_half = 3.1;
    rd_pct = 50;
    drive(300, 50);
    finish_group();
    drain();
    settle();
    check(q.size() == 0, "R9 all groups delivered at fast read clock", OW'(q.size()), OW'(0));

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule